// File: doc/BRIEF.md
# DMA Destination Address Guard

The guard sits between a DMA channel's transfer scheduler and its write phase. Each transfer record supplies a source address and a destination address. Either address may point at memory or at a peripheral. Before a write is issued, the guard compares the destination against two protected address windows: the DMA controller's own register window and its descriptor RAM window. A destination inside either window would let a badly programmed transfer corrupt the controller's configuration. Such a destination is refused. The write is suppressed, a sticky destination error flag is set, and a one-cycle abort pulse carries the job number so the scheduler can terminate that job.

Reads are never refused. The source address is run through the same window comparators only to report, as information, that the read side touches protected space. An error interrupt follows the sticky flag while the global error-interrupt enable is high. Every output is registered. A strobed record produces its response exactly one clock edge after it is presented, so the guard accepts one record per cycle.

Top module: `dmag_dst_guard`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every output is 0.
- R2: A record strobed with `chk_valid` whose destination lies in [REG_BASE, REG_BASE+REG_SIZE), compared on the full address width, gives `resp_valid`=1 and `wr_allow`=0 one cycle later.
- R3: A strobed destination in [RAM_BASE, RAM_BASE+RAM_SIZE) is refused in the same way as in R2.
- R4: A strobed destination outside both windows, including the address just below each base and the address equal to each exclusive end, gives `resp_valid`=1 and `wr_allow`=1 one cycle later, with no abort and no change to the error flag.
- R5: The source address never affects `wr_allow`, the abort pulse or the error flag. `resp_src_prot` is 1 one cycle after a strobe exactly when the source lies in either window.
- R6: A refused record produces `abort_valid`=1 for exactly one cycle, with `abort_job` equal to the strobed `chk_job`. When no abort is pending, `abort_job` reads 0.
- R7: `err_flag` is set by a refused record and stays set until an `err_clr` pulse with no refusal in the same cycle. A refusal and a clear in the same cycle leave the flag set.
- R8: `err_irq` is a register loaded every edge with the new flag value AND `err_int_en`, so it rises and falls one cycle after the flag or the enable changes.
- R9: With `chk_valid` low, `resp_valid`, `wr_allow`, `resp_src_prot` and `abort_valid` are 0 one cycle later, and the flag is unchanged apart from a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | A transfer record is presented this cycle |
| chk_src_addr | input | ADDR_W | Source (read) address of the record |
| chk_dst_addr | input | ADDR_W | Destination (write) address of the record |
| chk_job | input | JOB_W | Job number owning the record |
| err_int_en | input | 1 | Global error-interrupt enable |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| resp_valid | output | 1 | Decision for the record presented one cycle earlier |
| wr_allow | output | 1 | The write phase may be issued |
| resp_src_prot | output | 1 | The source of that record lies in a protected window |
| abort_valid | output | 1 | One-cycle abort request for a refused record |
| abort_job | output | JOB_W | Job number to abort |
| err_flag | output | 1 | Sticky destination address error |
| err_irq | output | 1 | Error interrupt request |

## Verification
The hardest cases are the window edges: the last address inside each window and the first address past its exclusive end. A single off-by-one slip in a compare would still pass any test that uses only interior addresses. The bench therefore sweeps every address within two of each base and each end, plus the extremes of the address space. Each sweep point pairs a destination with a source from the opposite category, so leakage from the source side into the decision is visible. The sticky flag's corner, where a refusal and a clear land in the same cycle, is forced by driving both in one step. Interrupt gating is then exercised by toggling the enable while the flag is held.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  localparam int NUM_WIN = 2;

  typedef enum logic [0:0] {
    WIN_REGS = 1'b0,
    WIN_DESC = 1'b1
  } win_idx_e;

  // Exclusive end of a window, one bit wider so a window reaching the top
  // of the address space does not wrap.
  function automatic logic [32:0] win_end(input logic [31:0] base,
                                          input logic [31:0] size);
    return {1'b0, base} + {1'b0, size};
  endfunction

endpackage

// File: rtl/dmag_win_cmp.sv
module dmag_win_cmp #(
  parameter int          ADDR_W = 32,
  parameter logic [31:0] BASE   = 32'h0,
  parameter logic [31:0] SIZE   = 32'h0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  import dmag_pkg::*;

  localparam logic [ADDR_W:0] LO = {1'b0, BASE[ADDR_W-1:0]};
  localparam logic [32:0]     HI_FULL = win_end(BASE, SIZE);
  localparam logic [ADDR_W:0] HI = HI_FULL[ADDR_W:0];

  logic [ADDR_W:0] addr_x;

  always_comb begin
    addr_x = {1'b0, addr};
    hit    = (addr_x >= LO) && (addr_x < HI);
  end

endmodule

// File: rtl/dmag_err_ctrl.sv
module dmag_err_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_err,
  input  logic clr_err,
  input  logic int_en,
  output logic flag,
  output logic irq
);

  logic flag_nxt;

  always_comb begin
    if (set_err)      flag_nxt = 1'b1;
    else if (clr_err) flag_nxt = 1'b0;
    else              flag_nxt = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt & int_en;
    end
  end

  // R7: flag only drops on a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(flag) && !$past(clr_err)) |-> flag);
  // R7: a refusal always leaves the flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_err |=> flag);
  // R8: interrupt needs the enable from the previous cycle
  a_r8_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && $past(int_en)));

endmodule

// File: rtl/dmag_dst_guard.sv
module dmag_dst_guard #(
  parameter int          ADDR_W   = 32,
  parameter int          JOB_W    = 5,
  parameter logic [31:0] REG_BASE = 32'h4000_0000,
  parameter logic [31:0] REG_SIZE = 32'h0000_1000,
  parameter logic [31:0] RAM_BASE = 32'h4001_0000,
  parameter logic [31:0] RAM_SIZE = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_src_addr,
  input  logic [ADDR_W-1:0] chk_dst_addr,
  input  logic [JOB_W-1:0]  chk_job,
  input  logic              err_int_en,
  input  logic              err_clr,
  output logic              resp_valid,
  output logic              wr_allow,
  output logic              resp_src_prot,
  output logic              abort_valid,
  output logic [JOB_W-1:0]  abort_job,
  output logic              err_flag,
  output logic              err_irq
);
  import dmag_pkg::*;

  localparam logic [NUM_WIN-1:0][31:0] W_BASE = {RAM_BASE, REG_BASE};
  localparam logic [NUM_WIN-1:0][31:0] W_SIZE = {RAM_SIZE, REG_SIZE};

  logic [NUM_WIN-1:0] dst_hit;
  logic [NUM_WIN-1:0] src_hit;
  logic               refuse;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    dmag_win_cmp #(
      .ADDR_W(ADDR_W), .BASE(W_BASE[w]), .SIZE(W_SIZE[w])
    ) u_dst_cmp (
      .addr(chk_dst_addr), .hit(dst_hit[w])
    );
    dmag_win_cmp #(
      .ADDR_W(ADDR_W), .BASE(W_BASE[w]), .SIZE(W_SIZE[w])
    ) u_src_cmp (
      .addr(chk_src_addr), .hit(src_hit[w])
    );
  end

  assign refuse = chk_valid && (|dst_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid    <= 1'b0;
      wr_allow      <= 1'b0;
      resp_src_prot <= 1'b0;
      abort_valid   <= 1'b0;
      abort_job     <= '0;
    end else begin
      resp_valid    <= chk_valid;
      wr_allow      <= chk_valid && !(|dst_hit);
      resp_src_prot <= chk_valid && (|src_hit);
      abort_valid   <= refuse;
      abort_job     <= refuse ? chk_job : '0;
    end
  end

  dmag_err_ctrl u_err (
    .clk(clk), .rst(rst),
    .set_err(refuse), .clr_err(err_clr), .int_en(err_int_en),
    .flag(err_flag), .irq(err_irq)
  );

  // R9: a response only follows a strobe
  a_r9_resp_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(chk_valid));
  // R4: a permitted write never aborts
  a_r4_allow_excl_abort: assert property (@(posedge clk) disable iff (rst)
    !(wr_allow && abort_valid));
  // R2: a refused response always carries an abort
  a_r2_refusal_aborts: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !wr_allow) |-> abort_valid);
  // R6: an abort is always accompanied by the sticky flag
  a_r6_abort_flags: assert property (@(posedge clk) disable iff (rst)
    abort_valid |-> err_flag);
  // R6: abort job is zero when idle
  a_r6_job_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !abort_valid |-> (abort_job == '0));

endmodule

// File: tb/dmag_dst_guard_tb.sv
module dmag_dst_guard_tb;

  localparam logic [31:0] RB = 32'h4000_0000;
  localparam logic [31:0] RS = 32'h0000_1000;
  localparam logic [31:0] MB = 32'h4001_0000;
  localparam logic [31:0] MS = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chk_valid = 1'b0;
  logic [31:0] chk_src_addr = '0;
  logic [31:0] chk_dst_addr = '0;
  logic [4:0]  chk_job = '0;
  logic        err_int_en = 1'b0;
  logic        err_clr = 1'b0;
  logic        resp_valid, wr_allow, resp_src_prot, abort_valid;
  logic [4:0]  abort_job;
  logic        err_flag, err_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_flag = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmag_dst_guard #(
    .ADDR_W(32), .JOB_W(5),
    .REG_BASE(RB), .REG_SIZE(RS), .RAM_BASE(MB), .RAM_SIZE(MS)
  ) u_dut (
    .clk(clk), .rst(rst), .chk_valid(chk_valid),
    .chk_src_addr(chk_src_addr), .chk_dst_addr(chk_dst_addr),
    .chk_job(chk_job), .err_int_en(err_int_en), .err_clr(err_clr),
    .resp_valid(resp_valid), .wr_allow(wr_allow),
    .resp_src_prot(resp_src_prot), .abort_valid(abort_valid),
    .abort_job(abort_job), .err_flag(err_flag), .err_irq(err_irq)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] s);
    longint ua = longint'(a);
    longint ub = longint'(b);
    return (ua >= ub) && (ua < ub + longint'(s));
  endfunction

  // One cycle: drive at negedge, model the edge, sample 1 ns after it.
  task automatic step(input bit v, input logic [31:0] src,
                      input logic [31:0] dst, input logic [4:0] job,
                      input bit clr, input string tag);
    bit in_reg, in_ram, blk, sprot;
    string rq;
    @(negedge clk);
    chk_valid = v; chk_src_addr = src; chk_dst_addr = dst;
    chk_job = job; err_clr = clr;
    in_reg = in_win(dst, RB, RS);
    in_ram = in_win(dst, MB, MS);
    blk    = v && (in_reg || in_ram);
    sprot  = v && (in_win(src, RB, RS) || in_win(src, MB, MS));
    if (blk) exp_flag = 1'b1;
    else if (clr) exp_flag = 1'b0;
    @(posedge clk);
    #1;
    if (tag != "") rq = tag;
    else if (!v) rq = "R9";
    else if (in_reg) rq = "R2";
    else if (in_ram) rq = "R3";
    else rq = "R4";
    check(rq, "resp_valid", resp_valid, v);
    check(rq, "wr_allow", wr_allow, v && !blk);
    check("R5", "resp_src_prot", resp_src_prot, sprot);
    check("R6", "abort_valid", abort_valid, blk);
    check("R6", "abort_job", abort_job, blk ? job : 5'd0);
    check("R7", "err_flag", err_flag, exp_flag);
    check("R8", "err_irq", err_irq, exp_flag && err_int_en);
    chk_valid = 1'b0; err_clr = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] edges [4];
    logic [31:0] extra [3];
    int j;
    edges[0] = RB; edges[1] = RB + RS; edges[2] = MB; edges[3] = MB + MS;
    extra[0] = 32'h0; extra[1] = 32'hFFFF_FFFF; extra[2] = 32'h8000_0000;

    repeat (3) @(negedge clk);
    #1;
    check("R1", "resp_valid", resp_valid, 0);
    check("R1", "wr_allow", wr_allow, 0);
    check("R1", "abort_valid", abort_valid, 0);
    check("R1", "err_flag", err_flag, 0);
    check("R1", "err_irq", err_irq, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4 boundary sweep; source taken from the opposite category (R5)
    j = 0;
    for (int e = 0; e < 4; e++) begin
      for (int d = -2; d <= 2; d++) begin
        logic [31:0] dst = edges[e] + 32'(d);
        bit prot = in_win(dst, RB, RS) || in_win(dst, MB, MS);
        logic [31:0] src = prot ? 32'h1000_0000 : RB + 32'h4;
        step(1'b1, src, dst, 5'(j), 1'b0, "");
        step(1'b0, 32'h0, dst, 5'd0, 1'b0, "R6");
        j++;
      end
    end
    for (int k = 0; k < 3; k++) begin
      step(1'b1, MB + 32'h10, extra[k], 5'(j), 1'b0, "R5");
      j++;
    end

    // R7: clear, then refusal and clear together
    step(1'b0, 32'h0, 32'h0, 5'd0, 1'b1, "R7");
    step(1'b0, 32'h0, RB, 5'd0, 1'b0, "R9");
    step(1'b1, 32'h0, MB + MS - 1, 5'd31, 1'b1, "R7");
    step(1'b1, 32'h0, 32'h2000_0000, 5'd3, 1'b0, "R7");

    // R8: enable toggling with flag held, then clear
    @(negedge clk); err_int_en = 1'b1;
    step(1'b0, 32'h0, 32'h0, 5'd0, 1'b0, "R8");
    @(negedge clk); err_int_en = 1'b0;
    step(1'b0, 32'h0, 32'h0, 5'd0, 1'b0, "R8");
    @(negedge clk); err_int_en = 1'b1;
    step(1'b0, 32'h0, 32'h0, 5'd0, 1'b1, "R8");
    step(1'b1, RB, RB + RS - 1, 5'd17, 1'b0, "R2");
    step(1'b0, 32'h0, 32'h0, 5'd0, 1'b0, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule